// File: doc/BRIEF.md
# Inter-Frame Gap Deferral Timer

This block decides when a queued transmit frame may start. It measures a quiet period in bit times after the previous frame. The period begins when the transmitter reports that a frame has left the interface, or when the MAC becomes idle. A frame that is waiting is released by a one-cycle grant pulse once the gap has been timed out. The gap length comes from configuration. Each new period takes a copy of the configured length when it starts.

In full-duplex mode the timer only counts. In half-duplex mode carrier sense is also checked, and its effect depends on where the count stands. While the count is below two thirds of the gap (rounded down), carrier sense sends the count back to zero. Once the count has passed that point, carrier sense is ignored and the count runs on to the end. Both the grant path and the counter stay idle after a grant until the next start event.

Top module: `ifg_defer_timer`

## Requirements
- R1: A start event is a one-cycle `tx_done` or a low-to-high change of `mac_idle`. It clears the count to zero and captures `gap_len`. With `bit_tick` high every cycle, no carrier and `frame_pend` held high, `tx_grant` rises exactly `gap_len + 1` clock edges after the edge that samples the start event.
- R2: The count advances only on cycles where `bit_tick` is high. While `bit_tick` is low, no grant is produced for a frame started with a non-zero gap.
- R3: A frame that is pending while the gap is still running is held until the count reaches the captured gap length. It is granted on the next edge after that.
- R4: A frame that becomes pending after the gap has already completed is granted on the first edge that samples `frame_pend` high.
- R5: In half-duplex mode (`half_duplex` = 1), carrier sense sampled while the count is strictly below floor(2·gap/3) reloads the count to zero. The frame start is then pushed back by the number of edges already counted.
- R6: In half-duplex mode, carrier sense sampled while the count is at or above floor(2·gap/3) has no effect, and the grant arrives at the unchanged time.
- R7: In full-duplex mode (`half_duplex` = 0), carrier sense has no effect on the grant time at any point in the gap.
- R8: `tx_grant` is high for exactly one cycle. No further grant is produced until the next start event, even if `frame_pend` stays high.
- R9: A synchronous active-high `rst` drives `tx_grant` low and leaves the block in the gap-complete state. A frame pending right after reset is granted on the first edge.
- R10: A change of `gap_len` during a running gap does not change that gap. The new value is used from the next start event.
- R11: A start event while a gap is running restarts the count from zero.
- R12: A start event with `gap_len` = 0 makes the gap complete at once, so a pending frame is granted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| gap_len | input | GAP_W | Configured gap length in bit times |
| half_duplex | input | 1 | 1 = half-duplex carrier handling, 0 = full duplex |
| crs | input | 1 | Carrier sense |
| tx_done | input | 1 | Previous frame finished on the interface (pulse) |
| mac_idle | input | 1 | MAC idle indication (rising edge starts a gap) |
| frame_pend | input | 1 | A transmit frame is waiting |
| tx_grant | output | 1 | One-cycle permission to start the frame |

## Verification
The bench measures the grant latency after each kind of start, with carrier sense pulsed at chosen counts. This separates reloads in the early region from carrier that is ignored late in the gap. The pulses sit on both sides of the two-thirds boundary, so an off-by-one in the region compare changes the measured latency. Further runs vary duplex mode, tick gating, the timing of the pending request, gap lengths of zero and one, and a mid-gap reconfiguration or restart. Each of these shifts the grant edge by a known amount.

// File: rtl/ifg_defer_pkg.sv
package ifg_defer_pkg;

   typedef enum logic [1:0] {
      GS_READY = 2'd0,
      GS_COUNT = 2'd1,
      GS_HOLD  = 2'd2
   } gap_state_e;

   // boundary between the reload region and the run-through region
   function automatic logic [31:0] early_limit(input logic [31:0] g);
      return (g * 32'd2) / 32'd3;
   endfunction

endpackage

// File: rtl/ifg_start_detect.sv
module ifg_start_detect (
   input  logic clk,
   input  logic rst,
   input  logic tx_done,
   input  logic mac_idle,
   output logic start_evt
);
   logic idle_q;

   // idle_q resets high so a level already present at reset is not an edge
   always_ff @(posedge clk) begin
      if (rst) idle_q <= 1'b1;
      else     idle_q <= mac_idle;
   end

   assign start_evt = tx_done | (mac_idle & ~idle_q);
endmodule

// File: rtl/ifg_limit_latch.sv
module ifg_limit_latch #(
   parameter int GAP_W            = 10,
   parameter bit PRECOMPUTE_BOUND = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [GAP_W-1:0] gap_in,
   output logic [GAP_W-1:0] gap_q,
   output logic [GAP_W-1:0] early_q
);
   import ifg_defer_pkg::*;

   localparam int PAD_W = 32 - GAP_W;

   always_ff @(posedge clk) begin
      if (rst)       gap_q <= '0;
      else if (load) gap_q <= gap_in;
   end

   generate
      if (PRECOMPUTE_BOUND) begin : g_reg_bound
         logic [31:0] early_new;
         assign early_new = early_limit({{PAD_W{1'b0}}, gap_in});
         always_ff @(posedge clk) begin
            if (rst)       early_q <= '0;
            else if (load) early_q <= early_new[GAP_W-1:0];
         end
      end else begin : g_comb_bound
         logic [31:0] early_cur;
         assign early_cur = early_limit({{PAD_W{1'b0}}, gap_q});
         assign early_q   = early_cur[GAP_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/ifg_gap_counter.sv
module ifg_gap_counter #(
   parameter int GAP_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_evt,
   input  logic             start_zero,
   input  logic             bit_tick,
   input  logic             half_duplex,
   input  logic             crs,
   input  logic [GAP_W-1:0] gap_lim,
   input  logic [GAP_W-1:0] early_lim,
   input  logic             grant_fire,
   output logic [GAP_W-1:0] cnt_q,
   output logic             ready,
   output logic             busy,
   output logic             holding
);
   import ifg_defer_pkg::*;

   gap_state_e       state_q;
   logic [GAP_W:0]   cnt_inc;
   logic             early_hit;

   assign cnt_inc   = {1'b0, cnt_q} + (GAP_W+1)'(1);
   assign early_hit = half_duplex & crs & (cnt_q < early_lim);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= GS_READY;
         cnt_q   <= '0;
      end else if (start_evt) begin
         cnt_q   <= '0;
         state_q <= start_zero ? GS_READY : GS_COUNT;
      end else begin
         unique case (state_q)
            GS_COUNT: begin
               if (early_hit) begin
                  cnt_q <= '0;
               end else if (bit_tick) begin
                  cnt_q <= cnt_inc[GAP_W-1:0];
                  if (cnt_inc >= {1'b0, gap_lim}) state_q <= GS_READY;
               end
            end
            GS_READY: if (grant_fire) state_q <= GS_HOLD;
            GS_HOLD:  state_q <= GS_HOLD;
            default:  state_q <= GS_READY;
         endcase
      end
   end

   assign ready   = (state_q == GS_READY);
   assign busy    = (state_q == GS_COUNT);
   assign holding = (state_q == GS_HOLD);
endmodule

// File: rtl/ifg_grant_ctrl.sv
module ifg_grant_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic ready,
   input  logic start_evt,
   input  logic frame_pend,
   output logic grant_fire,
   output logic tx_grant
);
   assign grant_fire = ready & frame_pend & ~start_evt;

   always_ff @(posedge clk) begin
      if (rst) tx_grant <= 1'b0;
      else     tx_grant <= grant_fire;
   end
endmodule

// File: rtl/ifg_defer_timer.sv
module ifg_defer_timer #(
   parameter int GAP_W            = 10,
   parameter bit PRECOMPUTE_BOUND = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_tick,
   input  logic [GAP_W-1:0] gap_len,
   input  logic             half_duplex,
   input  logic             crs,
   input  logic             tx_done,
   input  logic             mac_idle,
   input  logic             frame_pend,
   output logic             tx_grant
);
   generate
      if (GAP_W < 2 || GAP_W > 24) begin : g_bad_gap_w
         $error("ifg_defer_timer: GAP_W must lie in 2..24");
      end
   endgenerate

   logic             start_evt;
   logic             start_zero;
   logic [GAP_W-1:0] gap_q;
   logic [GAP_W-1:0] early_q;
   logic [GAP_W-1:0] cnt_q;
   logic             ready;
   logic             busy;
   logic             holding;
   logic             grant_fire;

   assign start_zero = (gap_len == '0);

   ifg_start_detect u_start (
      .clk       (clk),
      .rst       (rst),
      .tx_done   (tx_done),
      .mac_idle  (mac_idle),
      .start_evt (start_evt)
   );

   ifg_limit_latch #(
      .GAP_W            (GAP_W),
      .PRECOMPUTE_BOUND (PRECOMPUTE_BOUND)
   ) u_limit (
      .clk     (clk),
      .rst     (rst),
      .load    (start_evt),
      .gap_in  (gap_len),
      .gap_q   (gap_q),
      .early_q (early_q)
   );

   ifg_gap_counter #(
      .GAP_W (GAP_W)
   ) u_count (
      .clk         (clk),
      .rst         (rst),
      .start_evt   (start_evt),
      .start_zero  (start_zero),
      .bit_tick    (bit_tick),
      .half_duplex (half_duplex),
      .crs         (crs),
      .gap_lim     (gap_q),
      .early_lim   (early_q),
      .grant_fire  (grant_fire),
      .cnt_q       (cnt_q),
      .ready       (ready),
      .busy        (busy),
      .holding     (holding)
   );

   ifg_grant_ctrl u_grant (
      .clk        (clk),
      .rst        (rst),
      .ready      (ready),
      .start_evt  (start_evt),
      .frame_pend (frame_pend),
      .grant_fire (grant_fire),
      .tx_grant   (tx_grant)
   );
endmodule

// File: rtl/ifg_defer_timer_chk.sv
module ifg_defer_timer_chk #(
   parameter int GAP_W = 10
) (
   input logic             clk,
   input logic             rst,
   input logic             bit_tick,
   input logic [GAP_W-1:0] gap_len,
   input logic             half_duplex,
   input logic             crs,
   input logic             frame_pend,
   input logic             tx_grant,
   input logic             start_evt,
   input logic [GAP_W-1:0] cnt_q,
   input logic [GAP_W-1:0] early_q,
   input logic             ready,
   input logic             busy,
   input logic             holding
);
   a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
      start_evt |=> (cnt_q == '0));

   a_r2_no_tick_no_step: assert property (@(posedge clk) disable iff (rst)
      (busy && !bit_tick && !start_evt && !(half_duplex && crs)) |=> $stable(cnt_q));

   a_r3_grant_needs_pend: assert property (@(posedge clk) disable iff (rst)
      tx_grant |-> $past(frame_pend));

   a_r5_early_reload: assert property (@(posedge clk) disable iff (rst)
      (busy && half_duplex && crs && (cnt_q < early_q) && !start_evt) |=> (cnt_q == '0));

   a_r6_late_runs_on: assert property (@(posedge clk) disable iff (rst)
      (busy && crs && bit_tick && (cnt_q >= early_q) && !start_evt)
      |=> (cnt_q == $past(cnt_q) + GAP_W'(1)));

   a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
      tx_grant |=> !tx_grant);

   a_r8_hold_after: assert property (@(posedge clk) disable iff (rst)
      (holding && !start_evt) |=> !tx_grant);

   a_r9_reset_quiet: assert property (@(posedge clk)
      rst |=> !tx_grant);

   a_r12_zero_gap: assert property (@(posedge clk) disable iff (rst)
      (start_evt && (gap_len == '0)) |=> ready);
endmodule

bind ifg_defer_timer ifg_defer_timer_chk #(.GAP_W(GAP_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .bit_tick    (bit_tick),
   .gap_len     (gap_len),
   .half_duplex (half_duplex),
   .crs         (crs),
   .frame_pend  (frame_pend),
   .tx_grant    (tx_grant),
   .start_evt   (start_evt),
   .cnt_q       (cnt_q),
   .early_q     (early_q),
   .ready       (ready),
   .busy        (busy),
   .holding     (holding)
);

// File: tb/ifg_defer_timer_test.sv
`timescale 1ns/1ps
module ifg_defer_timer_test;
   localparam int GW = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          bit_tick = 1'b1;
   logic [GW-1:0] gap_len = GW'(12);
   logic          half_duplex = 1'b0;
   logic          crs = 1'b0;
   logic          tx_done = 1'b0;
   logic          mac_idle = 1'b0;
   logic          frame_pend = 1'b0;
   logic          tx_grant;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ifg_defer_timer #(.GAP_W(GW)) uut (
      .clk(clk), .rst(rst), .bit_tick(bit_tick), .gap_len(gap_len),
      .half_duplex(half_duplex), .crs(crs), .tx_done(tx_done),
      .mac_idle(mac_idle), .frame_pend(frame_pend), .tx_grant(tx_grant)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // kind: 0 no start, 1 tx_done, 2 mac_idle rise. *_at counts edges after the start edge.
   task automatic run_gap(input int kind, input int crs_at, input int chg_at,
                          input int chg_val, input int re_at, output int lat);
      if (kind != 0) begin
         if (kind == 1) tx_done = 1'b1;
         else           mac_idle = 1'b1;
         @(posedge clk); @(negedge clk);
         tx_done = 1'b0;
      end
      lat = -1;
      for (int n = 0; n < 400; n++) begin
         if (tx_grant) begin lat = n; break; end
         crs     = (crs_at > 0) && (n + 1 == crs_at);
         tx_done = (re_at > 0) && (n + 1 == re_at);
         if (chg_at > 0 && n + 1 == chg_at) gap_len = GW'(chg_val);
         @(posedge clk); @(negedge clk);
      end
      crs = 1'b0; tx_done = 1'b0; mac_idle = 1'b0;
   endtask

   task automatic t_reset;
      int lat;
      check(tx_grant == 1'b0, "R9 grant low in reset", tx_grant, 0);
      frame_pend = 1'b1;
      rst = 1'b0;
      run_gap(0, 0, 0, 0, 0, lat);
      check(lat == 1, "R9 pending after reset granted first edge", lat, 1);
      @(posedge clk); @(negedge clk);
      check(tx_grant == 1'b0, "R8 grant single cycle", tx_grant, 0);
   endtask

   task automatic t_full_basic;
      int lat;
      half_duplex = 1'b0; gap_len = GW'(12);
      run_gap(1, 0, 0, 0, 0, lat);
      check(lat == 13, "R1 R3 full duplex tx_done latency", lat, 13);
      gap_len = GW'(1);
      run_gap(1, 0, 0, 0, 0, lat);
      check(lat == 2, "R1 gap of one", lat, 2);
      gap_len = GW'(0);
      run_gap(1, 0, 0, 0, 0, lat);
      check(lat == 1, "R12 zero gap", lat, 1);
      gap_len = GW'(12);
      run_gap(2, 0, 0, 0, 0, lat);
      check(lat == 13, "R1 mac_idle rise start", lat, 13);
      run_gap(1, 3, 0, 0, 0, lat);
      check(lat == 13, "R7 full duplex carrier ignored", lat, 13);
   endtask

   task automatic t_half;
      int lat;
      int bnd;
      half_duplex = 1'b1; gap_len = GW'(12);
      bnd = (2 * 12) / 3;
      run_gap(1, 3, 0, 0, 0, lat);
      check(lat == 16, "R5 early carrier reloads", lat, 16);
      run_gap(1, bnd, 0, 0, 0, lat);
      check(lat == 13 + bnd, "R5 carrier at last early count", lat, 13 + bnd);
      run_gap(1, bnd + 1, 0, 0, 0, lat);
      check(lat == 13, "R6 carrier at boundary ignored", lat, 13);
      run_gap(1, 12, 0, 0, 0, lat);
      check(lat == 13, "R6 carrier at final count ignored", lat, 13);
      gap_len = GW'(3);
      run_gap(1, 2, 0, 0, 0, lat);
      check(lat == 6, "R5 short gap early carrier", lat, 6);
      run_gap(1, 3, 0, 0, 0, lat);
      check(lat == 4, "R6 short gap late carrier", lat, 4);
      half_duplex = 1'b0;
   endtask

   task automatic t_late_pend;
      int lat;
      frame_pend = 1'b0; gap_len = GW'(12);
      tx_done = 1'b1;
      @(posedge clk); @(negedge clk);
      tx_done = 1'b0;
      for (int i = 0; i < 20; i++) begin @(posedge clk); @(negedge clk); end
      check(tx_grant == 1'b0, "R3 no grant without pending", tx_grant, 0);
      frame_pend = 1'b1;
      run_gap(0, 0, 0, 0, 0, lat);
      check(lat == 1, "R4 late pending granted next edge", lat, 1);
      begin
         int seen = 0;
         for (int i = 0; i < 25; i++) begin
            @(posedge clk); @(negedge clk);
            if (tx_grant) seen++;
         end
         check(seen == 0, "R8 no second grant before next start", seen, 0);
      end
   endtask

   task automatic t_tick;
      int lat;
      int seen = 0;
      gap_len = GW'(5);
      bit_tick = 1'b0;
      tx_done = 1'b1;
      @(posedge clk); @(negedge clk);
      tx_done = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(posedge clk); @(negedge clk);
         if (tx_grant) seen++;
      end
      check(seen == 0, "R2 no count without tick", seen, 0);
      bit_tick = 1'b1;
      run_gap(0, 0, 0, 0, 0, lat);
      check(lat == 6, "R2 count resumes on ticks", lat, 6);
   endtask

   task automatic t_reconfig;
      int lat;
      gap_len = GW'(12);
      run_gap(1, 0, 2, 3, 0, lat);
      check(lat == 13, "R10 mid-gap change ignored", lat, 13);
      run_gap(1, 0, 0, 0, 0, lat);
      check(lat == 4, "R10 new gap used at next start", lat, 4);
      gap_len = GW'(12);
      run_gap(1, 0, 0, 0, 5, lat);
      check(lat == 18, "R11 restart during gap", lat, 18);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      t_reset();
      t_full_basic();
      t_half();
      t_late_pend();
      t_tick();
      t_reconfig();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule